// File: doc/BRIEF.md
# DMA Channel Interrupt Event Generator

This block turns the transfer status of a multi-channel DMA engine into one interrupt request line per channel. Each channel has three interrupt causes. The first is a finished buffer whose end-of-buffer interrupt enable is set. The second is a threshold hit, where the remaining transfer length in direct mode reaches a programmed byte value. The third is a buffer cut short by an end-of-frame request. Every cause latches into its own pending bit, and the bit stays set until software acknowledges it with a write-one-to-clear.

The channels are fully independent and none has priority over another. Each channel drives its own request line, which is the OR of its three pending bits gated by that channel's master enable. The threshold cause is edge-qualified. It is evaluated only on a length-update strobe, and it fires only on the update where the match goes from false to true.

Top module: `dma_irq_gen`

## Requirements
- R1: After reset all pending bits and all interrupt outputs are 0.
- R2: A `buf_done_i[c]` strobe with `buf_ie_i[c]` = 1 sets `pend_o[3c+0]` on that clock edge.
- R3: A `buf_done_i[c]` strobe with `buf_ie_i[c]` = 0 sets no pending bit.
- R4: A `len_upd_i[c]` strobe with `direct_i[c]` = 1, length bits [15:8] equal to zero and length bits [7:0] equal to `thr_i` slice c sets `pend_o[3c+1]`, provided the previous update did not also match.
- R5: Further updates while the match stays true do not set `pend_o[3c+1]` again; the match history is refreshed on every update.
- R6: With `direct_i[c]` = 0 a matching length sets no pending bit.
- R7: A `frame_term_i[c]` strobe sets `pend_o[3c+2]` on that clock edge.
- R8: A pending bit stays set until a cycle with `clr_we_i` = 1 and a 1 in the same bit of `clr_data_i`; bits written with 0 are unchanged.
- R9: When an event and a clear of the same bit fall in one cycle, the bit stays set.
- R10: `irq_o[c]` is 1 exactly when `chan_ie_i[c]` = 1 and any of `pend_o[3c+2:3c]` is set; events on one channel never touch another channel's bits.
- R11: A length whose bits [15:8] are nonzero never matches, even when bits [7:0] equal the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_done_i | input | NUM_CH | Buffer-complete strobe per channel |
| buf_ie_i | input | NUM_CH | End-of-buffer interrupt enable of the completing buffer |
| frame_term_i | input | NUM_CH | Buffer-terminated-by-end-of-frame strobe |
| len_upd_i | input | NUM_CH | Length-decremented strobe; `len_i` holds the new value |
| direct_i | input | NUM_CH | Direct-mode flag per channel |
| len_i | input | NUM_CH*LEN_W | Remaining transfer length, channel c at [c*LEN_W +: LEN_W] |
| thr_i | input | NUM_CH*THR_W | Threshold byte, channel c at [c*THR_W +: THR_W] |
| chan_ie_i | input | NUM_CH | Master interrupt enable per channel |
| clr_we_i | input | 1 | Acknowledge write strobe |
| clr_data_i | input | 3*NUM_CH | Write-one-to-clear mask, same layout as `pend_o` |
| pend_o | output | 3*NUM_CH | Pending bits: 3c+0 end-of-buffer, 3c+1 threshold, 3c+2 end-of-frame |
| irq_o | output | NUM_CH | Interrupt request per channel |

## Verification
The bench repeats an update while the threshold match stays true. A level-sensitive design would re-raise the pending bit right after the clear. The bench also moves the length through a value with a nonzero high byte and back to a match. A design that ignored the high byte would fire early, and one that never refreshed its match history would stay silent on the re-arm. It collides a clear with a new event on the same bit, where a design that let the clear win would drop an interrupt. It also sends masked buffer completions, non-direct matches and disabled channels, where a wrongly gated design would raise requests nobody asked for.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

   localparam int unsigned CAUSE_N = 3;
   localparam int unsigned IDX_EOB = 0;
   localparam int unsigned IDX_THR = 1;
   localparam int unsigned IDX_EOF = 2;

   // packed order puts eob at bit 0, thr at bit 1, eof at bit 2
   typedef struct packed {
      logic eof;
      logic thr;
      logic eob;
   } cause_t;

endpackage

// File: rtl/dma_irq_thr_det.sv
module dma_irq_thr_det #(
   parameter int unsigned LEN_W = 16,
   parameter int unsigned THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic             direct_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [THR_W-1:0] thr_i,
   output logic             hit_o
);

   generate
      if (THR_W < 1 || LEN_W < THR_W) begin : g_bad_width
         $error("dma_irq_thr_det: need 1 <= THR_W <= LEN_W");
      end
   endgenerate

   logic upper_zero;
   logic match;
   logic seen_q;

   generate
      if (LEN_W > THR_W) begin : g_upper
         assign upper_zero = (len_i[LEN_W-1:THR_W] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign match = direct_i && upper_zero && (len_i[THR_W-1:0] == thr_i);

   // match history, refreshed on every length update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
      end else if (upd_i) begin
         seen_q <= match;
      end
   end

   assign hit_o = upd_i && match && !seen_q;

endmodule

// File: rtl/dma_irq_pend.sv
module dma_irq_pend #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);

   generate
      if (W < 1) begin : g_bad_width
         $error("dma_irq_pend: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] pend_q;

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_i) | set_i;
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
   import dma_irq_pkg::*;
#(
   parameter int unsigned LEN_W = 16,
   parameter int unsigned THR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               buf_done_i,
   input  logic               buf_ie_i,
   input  logic               frame_term_i,
   input  logic               len_upd_i,
   input  logic               direct_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic [THR_W-1:0]   thr_i,
   input  logic               chan_ie_i,
   input  logic [CAUSE_N-1:0] clr_i,
   output logic [CAUSE_N-1:0] pend_o,
   output logic               irq_o
);

   cause_t set;
   logic   thr_hit;

   dma_irq_thr_det #(
      .LEN_W (LEN_W),
      .THR_W (THR_W)
   ) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_i    (len_upd_i),
      .direct_i (direct_i),
      .len_i    (len_i),
      .thr_i    (thr_i),
      .hit_o    (thr_hit)
   );

   always_comb begin
      set     = '0;
      set.eob = buf_done_i && buf_ie_i;
      set.thr = thr_hit;
      set.eof = frame_term_i;
   end

   dma_irq_pend #(
      .W (CAUSE_N)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set),
      .clr_i  (clr_i),
      .pend_o (pend_o)
   );

   assign irq_o = chan_ie_i && (|pend_o);

endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned THR_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         buf_done_i,
   input  logic [NUM_CH-1:0]         buf_ie_i,
   input  logic [NUM_CH-1:0]         frame_term_i,
   input  logic [NUM_CH-1:0]         len_upd_i,
   input  logic [NUM_CH-1:0]         direct_i,
   input  logic [NUM_CH*LEN_W-1:0]   len_i,
   input  logic [NUM_CH*THR_W-1:0]   thr_i,
   input  logic [NUM_CH-1:0]         chan_ie_i,
   input  logic                      clr_we_i,
   input  logic [NUM_CH*CAUSE_N-1:0] clr_data_i,
   output logic [NUM_CH*CAUSE_N-1:0] pend_o,
   output logic [NUM_CH-1:0]         irq_o
);

   localparam int unsigned PEND_W = NUM_CH * CAUSE_N;

   generate
      if (NUM_CH < 1) begin : g_bad_count
         $error("dma_irq_gen: NUM_CH must be at least 1");
      end
   endgenerate

   logic [PEND_W-1:0] clr_mask;

   assign clr_mask = clr_we_i ? clr_data_i : '0;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         dma_irq_chan #(
            .LEN_W (LEN_W),
            .THR_W (THR_W)
         ) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .buf_done_i   (buf_done_i[c]),
            .buf_ie_i     (buf_ie_i[c]),
            .frame_term_i (frame_term_i[c]),
            .len_upd_i    (len_upd_i[c]),
            .direct_i     (direct_i[c]),
            .len_i        (len_i[c*LEN_W +: LEN_W]),
            .thr_i        (thr_i[c*THR_W +: THR_W]),
            .chan_ie_i    (chan_ie_i[c]),
            .clr_i        (clr_mask[c*CAUSE_N +: CAUSE_N]),
            .pend_o       (pend_o[c*CAUSE_N +: CAUSE_N]),
            .irq_o        (irq_o[c])
         );
      end
   endgenerate

endmodule

// File: rtl/dma_irq_gen_chk.sv
module dma_irq_gen_chk
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_CH-1:0]         buf_done_i,
   input logic [NUM_CH-1:0]         buf_ie_i,
   input logic [NUM_CH-1:0]         frame_term_i,
   input logic [NUM_CH-1:0]         len_upd_i,
   input logic [NUM_CH-1:0]         direct_i,
   input logic [NUM_CH-1:0]         chan_ie_i,
   input logic                      clr_we_i,
   input logic [NUM_CH*CAUSE_N-1:0] clr_data_i,
   input logic [NUM_CH*CAUSE_N-1:0] pend_o,
   input logic [NUM_CH-1:0]         irq_o
);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam int unsigned B = c * CAUSE_N;

         assert_eob_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_done_i[c] && buf_ie_i[c]) |=> pend_o[B+IDX_EOB]);

         assert_eob_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_done_i[c] && !buf_ie_i[c] && !pend_o[B+IDX_EOB]) |=> !pend_o[B+IDX_EOB]);

         assert_thr_needs_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_o[B+IDX_THR] && !(len_upd_i[c] && direct_i[c])) |=> !pend_o[B+IDX_THR]);

         assert_eof_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
            frame_term_i[c] |=> pend_o[B+IDX_EOF]);

         assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_ie_i[c] |-> !irq_o[c]);

         assert_irq_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (pend_o[B +: CAUSE_N] != '0));

         for (genvar k = 0; k < CAUSE_N; k++) begin : g_bit
            assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
               (pend_o[B+k] && !(clr_we_i && clr_data_i[B+k])) |=> pend_o[B+k]);
         end
      end
   endgenerate

endmodule

bind dma_irq_gen dma_irq_gen_chk #(
   .NUM_CH (NUM_CH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .buf_done_i   (buf_done_i),
   .buf_ie_i     (buf_ie_i),
   .frame_term_i (frame_term_i),
   .len_upd_i    (len_upd_i),
   .direct_i     (direct_i),
   .chan_ie_i    (chan_ie_i),
   .clr_we_i     (clr_we_i),
   .clr_data_i   (clr_data_i),
   .pend_o       (pend_o),
   .irq_o        (irq_o)
);

// File: tb/test_dma_irq_gen.sv
module test_dma_irq_gen;
   import dma_irq_pkg::*;

   localparam int NCH = 4;
   localparam int LW  = 16;
   localparam int TW  = 8;
   localparam int NP  = NCH * CAUSE_N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NCH-1:0]    done_s, ie_s, term_s, upd_s, dir_s, chie_s;
   logic [NCH*LW-1:0] len_s;
   logic [NCH*TW-1:0] thr_s;
   logic              clr_we_s;
   logic [NP-1:0]     clr_s;
   logic [NP-1:0]     pend;
   logic [NCH-1:0]    irq;

   dma_irq_gen #(.NUM_CH(NCH), .LEN_W(LW), .THR_W(TW)) i_dma_irq_gen (
      .clk(clk), .rst_n(rst_n), .buf_done_i(done_s), .buf_ie_i(ie_s),
      .frame_term_i(term_s), .len_upd_i(upd_s), .direct_i(dir_s),
      .len_i(len_s), .thr_i(thr_s), .chan_ie_i(chie_s),
      .clr_we_i(clr_we_s), .clr_data_i(clr_s), .pend_o(pend), .irq_o(irq)
   );

   typedef struct {
      logic [NP-1:0]  pend;
      logic [NCH-1:0] irq;
      string          req;
   } item_t;

   item_t          sb_q[$];
   int             compared = 0;
   int             mismatched = 0;
   logic [NP-1:0]  m_pend = '0;
   logic [NCH-1:0] m_prev = '0;
   bit             finished = 0;

   // driver: model one clock of the requirements, queue the expectation
   task automatic tick(string req);
      item_t         it;
      logic [NP-1:0] set;
      set = '0;
      for (int c = 0; c < NCH; c++) begin
         logic hit;
         hit = dir_s[c] && (len_s[c*LW+TW +: LW-TW] == '0) &&
               (len_s[c*LW +: TW] == thr_s[c*TW +: TW]);
         if (done_s[c] && ie_s[c]) set[c*3+0] = 1'b1;
         if (upd_s[c]) begin
            if (hit && !m_prev[c]) set[c*3+1] = 1'b1;
            m_prev[c] = hit;
         end
         if (term_s[c]) set[c*3+2] = 1'b1;
      end
      if (clr_we_s) m_pend = m_pend & ~clr_s;
      m_pend = m_pend | set;
      it.pend = m_pend;
      for (int c = 0; c < NCH; c++) it.irq[c] = (|m_pend[c*3 +: 3]) && chie_s[c];
      it.req = req;
      sb_q.push_back(it);
      @(posedge clk);
      @(negedge clk);
      done_s = '0; term_s = '0; upd_s = '0; clr_we_s = 1'b0; clr_s = '0;
   endtask

   // monitor: compare a quarter period after each active edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            compared++;
            if (pend !== it.pend || irq !== it.irq) begin
               mismatched++;
               $display("FAIL %s: pend=%h irq=%h expected pend=%h irq=%h",
                        it.req, pend, irq, it.pend, it.irq);
            end
         end
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      done_s = '0; ie_s = '0; term_s = '0; upd_s = '0; dir_s = '0;
      chie_s = '1; len_s = '1; thr_s = '0; clr_we_s = 1'b0; clr_s = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick("R1 reset state");

      done_s[0] = 1'b1; ie_s[0] = 1'b1;
      tick("R2 enabled buffer completion");
      ie_s[0] = 1'b0;

      done_s[1] = 1'b1;
      tick("R3 masked buffer completion");

      term_s[2] = 1'b1;
      tick("R7 end-of-frame termination");

      tick("R8 bits stay pending");

      clr_we_s = 1'b1; clr_s[0] = 1'b1;
      tick("R8 clear one bit");

      clr_s = '1;
      tick("R8 data without write strobe");

      dir_s[3] = 1'b1; thr_s[3*TW +: TW] = 8'h12; len_s[3*LW +: LW] = 16'h0012;
      upd_s[3] = 1'b1;
      tick("R4 threshold match");

      clr_we_s = 1'b1; clr_s[3*3+1] = 1'b1;
      tick("R8 clear threshold bit");

      upd_s[3] = 1'b1;
      tick("R5 match held, no repeat");

      len_s[3*LW +: LW] = 16'h0112; upd_s[3] = 1'b1;
      tick("R11 nonzero high byte");

      len_s[3*LW +: LW] = 16'h0012; upd_s[3] = 1'b1;
      tick("R4 re-armed match");

      dir_s[1] = 1'b0; thr_s[1*TW +: TW] = 8'h05; len_s[1*LW +: LW] = 16'h0005;
      upd_s[1] = 1'b1;
      tick("R6 non-direct match ignored");

      clr_we_s = 1'b1; clr_s[2*3+2] = 1'b1; term_s[2] = 1'b1;
      tick("R9 event beats clear");

      chie_s[2] = 1'b0;
      tick("R10 master enable off");
      chie_s[2] = 1'b1;

      done_s = '1; ie_s = 4'b0101;
      tick("R2 R3 R10 all channels at once");
      ie_s = '0;

      clr_we_s = 1'b1; clr_s = 12'b101_000_011_001;
      tick("R8 mixed clear mask");

      clr_we_s = 1'b1; clr_s = '1;
      tick("R8 R10 clear all");

      repeat (2) @(negedge clk);
      finished = 1;
      summary();
      $finish;
   end

endmodule